// File: doc/BRIEF.md
# Dual Blink PWM LED Driver

This block generates two independent blink/dim waveforms and routes them to eight open-drain LED pins. A fixed integer divider turns the system clock into a base step tick. Each of the two channels counts a programmable number of those ticks per phase step, and it walks an 8-bit phase through 256 steps. The channel is "on" while its phase is below its duty value. When the step rate is fast, an LED driven by the channel looks dimmed. When the step rate is slow, the LED visibly blinks.

Each output pin has its own 2-bit selector. The selector makes the pin released, pulled low, or a follower of either channel. The outputs are pull-low enables: 1 drives the pin low (LED on) and 0 releases it (LED off). Register writes take effect immediately. The counters are never restarted by a write, so one period after a change may be irregular. With the default divider and a 50 MHz clock, the tick runs near 38.9 kHz. That gives periods from about 6.6 ms (prescaler 0) to about 1.7 s (prescaler 255).

Top module: `dual_blink_led`

## Requirements
- R1: While `rst` is high and on the first clock after it, every bit of `led_pull` is 0 (released). Both phase counters restart from zero.
- R2: The base tick occurs once every `TICK_DIV` system clocks.
- R3: A channel's waveform repeats every 256*(PSC+1) base ticks, where PSC is that channel's prescaler value.
- R4: Within each period, a channel is on for exactly DUTY*(PSC+1) base ticks. This on-time forms one contiguous pulse, so there is one rising edge per period when 0 < DUTY.
- R5: A channel whose duty value is 0 is never on.
- R6: Selector encoding is 2'b00 released (pull bit 0), 2'b01 driven low (pull bit 1), 2'b10 follows channel 0, and 2'b11 follows channel 1.
- R7: Selector bits `sel_lo[2i+1:2i]` control output i for i = 0..3. Bits `sel_hi[2i+1:2i]` control output 4+i.
- R8: `led_pull` is registered. A selector change appears on the pin exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| psc0 | input | 8 | Channel 0 prescaler (ticks per phase step minus one) |
| duty0 | input | 8 | Channel 0 duty value |
| psc1 | input | 8 | Channel 1 prescaler |
| duty1 | input | 8 | Channel 1 duty value |
| sel_lo | input | 8 | Selector fields for outputs 0 to 3 |
| sel_hi | input | 8 | Selector fields for outputs 4 to 7 |
| led_pull | output | 8 | Pull-low enables, 1 = drive low (LED on) |

## Verification
The bench sweeps prescalers 0, 1 and 3 against duty values 0, 1, 2, 128 and 255. For each setting it counts on-cycles and rising edges over exactly one computed period. An off-by-one in the prescaler compare would stretch or shrink the period, and this shows up as a wrong on-count and a wrong edge count. A `<=` in place of `<` in the duty compare would light a zero-duty channel and add one step at every other duty. Swapped selector codes, or shifted field positions, would send the wrong channel to a pin, and the pins are checked against different channel settings. A selector step is timed to catch a missing or extra output register.

// File: rtl/dual_blink_pkg.sv
package dual_blink_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_ON   = 2'b01,
    SRC_CH0  = 2'b10,
    SRC_CH1  = 2'b11
  } src_sel_e;
endpackage

// File: rtl/blink_tick_gen.sv
module blink_tick_gen #(
  parameter int DIV = 1285
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (DIV > 1) begin : g_gap
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/blink_channel.sv
module blink_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] psc,
  input  logic [W-1:0] duty,
  output logic         active
);
  logic [W-1:0] pre_cnt;
  logic [W-1:0] phase;
  logic         step;

  assign step = tick && (pre_cnt >= psc);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      phase   <= '0;
    end else if (tick) begin
      if (pre_cnt >= psc) begin
        pre_cnt <= '0;
        phase   <= phase + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assign active = (phase < duty);

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    step |=> (phase == $past(phase) + 1'b1));
  p_zero_duty_r5: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |-> !active);
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import dual_blink_pkg::*;
#(
  parameter int NOUT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NOUT-1:0] sel_all,
  input  logic [1:0]        ch_active,
  output logic [NOUT-1:0]   pull
);
  generate
    for (genvar i = 0; i < NOUT; i++) begin : g_out
      src_sel_e src;
      logic     nxt;
      assign src = src_sel_e'(sel_all[2*i +: 2]);

      always_comb begin
        unique case (src)
          SRC_OFF: nxt = 1'b0;
          SRC_ON:  nxt = 1'b1;
          SRC_CH0: nxt = ch_active[0];
          SRC_CH1: nxt = ch_active[1];
          default: nxt = 1'b0;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) pull[i] <= 1'b0;
        else     pull[i] <= nxt;
      end

      p_sel_on_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_all[2*i +: 2] == 2'b01) |=> pull[i]);
      p_sel_off_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_all[2*i +: 2] == 2'b00) |=> !pull[i]);
      p_follow_ch0_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_all[2*i +: 2] == 2'b10) |=> (pull[i] == $past(ch_active[0])));
    end
  endgenerate
endmodule

// File: rtl/dual_blink_led.sv
module dual_blink_led #(
  parameter int TICK_DIV = 1285,
  parameter int W        = 8,
  parameter int NOUT     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    psc0,
  input  logic [W-1:0]    duty0,
  input  logic [W-1:0]    psc1,
  input  logic [W-1:0]    duty1,
  input  logic [NOUT-1:0] sel_lo,
  input  logic [NOUT-1:0] sel_hi,
  output logic [NOUT-1:0] led_pull
);
  localparam int NCH = 2;

  logic                  tick;
  logic [NCH-1:0][W-1:0] psc_a;
  logic [NCH-1:0][W-1:0] duty_a;
  logic [NCH-1:0]        active;

  assign psc_a  = {psc1, psc0};
  assign duty_a = {duty1, duty0};

  blink_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      blink_channel #(.W(W)) u_ch (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .psc    (psc_a[c]),
        .duty   (duty_a[c]),
        .active (active[c])
      );
    end
  endgenerate

  led_src_mux #(.NOUT(NOUT)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .sel_all   ({sel_hi, sel_lo}),
    .ch_active (active),
    .pull      (led_pull)
  );

  p_reset_release_r1: assert property (@(posedge clk)
    rst |=> (led_pull == '0));
endmodule

// File: tb/dual_blink_led_bench.sv
module dual_blink_led_bench;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] psc0 = 0, duty0 = 0, psc1 = 0, duty1 = 0;
  logic [7:0] sel_lo = 0, sel_hi = 0;
  logic [7:0] led_pull;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dual_blink_led #(.TICK_DIV(DIV)) u_dual_blink_led (
    .clk(clk), .rst(rst), .psc0(psc0), .duty0(duty0), .psc1(psc1),
    .duty1(duty1), .sel_lo(sel_lo), .sel_hi(sel_hi), .led_pull(led_pull)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample a window of P cycles; count on-cycles and rising edges per bit.
  task automatic window(int P, output int on_c[8], output int rise_c[8]);
    logic [7:0] prev;
    for (int b = 0; b < 8; b++) begin on_c[b] = 0; rise_c[b] = 0; end
    prev = led_pull;
    repeat (P) begin
      @(negedge clk);
      for (int b = 0; b < 8; b++) begin
        if (led_pull[b]) on_c[b]++;
        if (led_pull[b] && !prev[b]) rise_c[b]++;
      end
      prev = led_pull;
    end
  endtask

  initial begin
    int on_c[8], rise_c[8];
    int pscs[3]  = '{0, 1, 3};
    int duties[5] = '{0, 1, 2, 128, 255};
    // R1: reset wins over a selector that asks for drive-low
    sel_lo = 8'h55; sel_hi = 8'h55;
    repeat (3) @(negedge clk);
    check("R1 reset released", led_pull, 0);
    sel_lo = 8'h00; sel_hi = 8'h00;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 released after reset", led_pull, 0);

    // R8: single selector step, one-clock latency
    sel_lo = 8'b0000_0001;
    check("R8 not yet visible", led_pull[0], 0);
    @(negedge clk);
    check("R8 one clock later", led_pull[0], 1);

    // R6/R7 field map: out0 off,1 on,2 ch0,3 ch1 ; out4 ch1,5 ch0,6 on,7 off
    sel_lo = 8'b11_10_01_00;
    sel_hi = 8'b00_01_10_11;
    foreach (pscs[pi]) begin
      foreach (duties[di]) begin
        int p0, p1, d0, d1, per0, per1;
        p0 = pscs[pi]; d0 = duties[di];
        p1 = (pi + 1) % 3; p1 = pscs[p1]; d1 = 255 - d0;
        psc0 = 8'(p0); duty0 = 8'(d0); psc1 = 8'(p1); duty1 = 8'(d1);
        per0 = 256 * (p0 + 1) * DIV;
        per1 = 256 * (p1 + 1) * DIV;
        repeat (2 * ((per0 > per1) ? per0 : per1)) @(negedge clk);
        window(per0, on_c, rise_c);
        // R2, R3, R4, R5 on channel 0 through outputs 2 and 5 (R7)
        check("R4 ch0 on-time out2", on_c[2], d0 * (p0 + 1) * DIV);
        check("R3 ch0 one pulse out2", rise_c[2], (d0 > 0) ? 1 : 0);
        check("R7 ch0 on-time out5", on_c[5], d0 * (p0 + 1) * DIV);
        if (d0 == 0) check("R5 zero duty dark", on_c[2] + on_c[5], 0);
        check("R6 out0 off", on_c[0] + on_c[7], 0);
        check("R6 out1 on", on_c[1], per0);
        check("R6 out6 on", on_c[6], per0);
        window(per1, on_c, rise_c);
        check("R4 ch1 on-time out3", on_c[3], d1 * (p1 + 1) * DIV);
        check("R3 ch1 one pulse out3", rise_c[3], (d1 > 0) ? 1 : 0);
        check("R7 ch1 on-time out4", on_c[4], d1 * (p1 + 1) * DIV);
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule